// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Unit

This block is the request-capture and acknowledge logic that sits between sixteen interrupt lines and a pair of 8-line priority controllers. One controller is the primary and the other is the secondary. It keeps the request and in-service bits for both controllers. Each line can be made edge-triggered or level-triggered through a per-controller trigger-select register. The secondary controller reaches the processor only through primary line 2.

The two priority resolvers are outside this block. Each one reports whether it has a winning line and which line it is. When the processor raises the single-cycle `ack` strobe, the block forms the 8-bit interrupt vector in the same cycle. On the next clock edge it updates request bits, in-service bits and rotation bases. It follows the auto end-of-interrupt and rotate flags, it forwards the acknowledge down the cascade, and it produces a spurious line-7 vector when the request it expected has gone.

The vector output is combinational from the resolver inputs and the base inputs. All state changes happen on the clock edge after the strobe.

Top module: `casc_ack_unit`

## Requirements
- R1: An edge-triggered line sets its request bit at the clock edge where its input is sampled 1 after having been sampled 0. An input that stays high does not set the bit again after it has been acknowledged.
- R2: For a level-triggered line (trigger-select bit 1), the request bit equals the input level sampled at the previous clock edge. This holds at all times, including during acknowledge.
- R3: A trigger-select write stores the written byte ANDed with 0xF8 into the primary register when `trig_sec` is 0. When `trig_sec` is 1 it stores the byte ANDed with 0xDE into the secondary register. Both registers read back on their outputs and are 0 after reset.
- R4: Primary request bit 2 is set at every clock edge where `sec_win_valid` is 1. The primary input `irq_in[2]` has no effect on any state.
- R5: An acknowledge that hits a controller with its auto-EOI flag at 0 sets the in-service bit of the acknowledged line and leaves that controller's rotation base unchanged.
- R6: An acknowledge that hits a controller with auto-EOI at 1 leaves its in-service bits unchanged. If that controller's rotate flag is also 1, its rotation base becomes (line + 1) mod 8; otherwise the base is unchanged.
- R7: An acknowledge clears the request bit of the acknowledged line only if that line is edge-triggered.
- R8: When `ack` is 1, the primary winner is line 2 and the secondary has a winner, the secondary controller is acknowledged as well. The vector is then `sec_base[7:3]` concatenated with the secondary line.
- R9: When `ack` is 1, the primary winner is line 2 and the secondary has no winner, the vector is `sec_base[7:3]` concatenated with 3'b111. No secondary state changes.
- R10: When `ack` is 1 and the primary has no winner, the vector is `pri_base[7:3]` concatenated with 3'b111. No request, in-service or rotation state changes, apart from normal request capture.
- R11: When `ack` is 1 and the primary winner is a line other than 2, the vector is `pri_base[7:3]` concatenated with that line. The vector is valid in the same cycle as `ack`.
- R12: If a new edge on a line and the acknowledge of that same line arrive in the same cycle, the request bit ends cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 16 | Request lines: bits 7:0 primary, bits 15:8 secondary |
| trig_we | input | 1 | Trigger-select write strobe |
| trig_sec | input | 1 | Write target: 0 primary, 1 secondary |
| trig_wdata | input | 8 | Trigger-select write data |
| pri_aeoi | input | 1 | Primary auto end-of-interrupt flag |
| pri_rot | input | 1 | Primary rotate-on-auto-EOI flag |
| sec_aeoi | input | 1 | Secondary auto end-of-interrupt flag |
| sec_rot | input | 1 | Secondary rotate-on-auto-EOI flag |
| pri_base | input | 8 | Primary vector base, bits 7:3 used |
| sec_base | input | 8 | Secondary vector base, bits 7:3 used |
| pri_win_valid | input | 1 | Primary resolver has a winner |
| pri_win_line | input | 3 | Primary winning line |
| sec_win_valid | input | 1 | Secondary resolver has a winner |
| sec_win_line | input | 3 | Secondary winning line |
| ack | input | 1 | Single-cycle acknowledge strobe |
| vector | output | 8 | Interrupt vector, valid while ack is 1 |
| pri_req | output | 8 | Primary request bits |
| sec_req | output | 8 | Secondary request bits |
| pri_isr | output | 8 | Primary in-service bits |
| sec_isr | output | 8 | Secondary in-service bits |
| pri_rot_base | output | 3 | Primary rotation base |
| sec_rot_base | output | 3 | Secondary rotation base |
| pri_trig | output | 8 | Primary trigger-select register |
| sec_trig | output | 8 | Secondary trigger-select register |

## Verification
A wrong request, in-service or rotation bit shows on the state outputs at the very next negative clock edge after the cycle that should have produced it. The bench compares every such output against its own model after every cycle. A wrong cascade decision or a missed spurious case shows in the vector during the acknowledge cycle itself. A stale trigger-select bit is seen one cycle later as a request bit that follows the wrong capture rule. A lost or extra acknowledge on the secondary controller is seen as a mismatch in `sec_isr`, `sec_req` or `sec_rot_base`, even when the vector is correct.

// File: rtl/casc_ack_pkg.sv
package casc_ack_pkg;
  localparam int LINES     = 8;
  localparam int IDX_W     = $clog2(LINES);
  localparam int VEC_W     = 8;
  localparam int CASC_LINE = 2;
  localparam logic [LINES-1:0] PRI_TRIG_MASK = 8'hF8;
  localparam logic [LINES-1:0] SEC_TRIG_MASK = 8'hDE;

  typedef struct packed {
    logic             en;
    logic [IDX_W-1:0] line;
  } ack_cmd_t;
endpackage

// File: rtl/casc_ack_lane.sv
module casc_ack_lane
  import casc_ack_pkg::*;
#(
  parameter logic [LINES-1:0] TRIG_MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines_in,
  input  logic [LINES-1:0] force_set,
  input  logic             trig_we,
  input  logic [LINES-1:0] trig_wdata,
  input  ack_cmd_t         cmd,
  input  logic             auto_eoi,
  input  logic             rot_aeoi,
  output logic [LINES-1:0] req_q,
  output logic [LINES-1:0] isr_q,
  output logic [IDX_W-1:0] rot_q,
  output logic [LINES-1:0] trig_q
);
  logic [LINES-1:0] last_q;
  logic [LINES-1:0] req_d, isr_d, trig_d, ack_hot, edge_set;
  logic [IDX_W-1:0] rot_d;

  always_comb begin
    ack_hot  = cmd.en ? (LINES'(1) << cmd.line) : '0;
    edge_set = (lines_in & ~last_q) | force_set;
    // level lines follow the input; edge lines latch, and an acknowledge clear wins
    req_d    = (trig_q & lines_in) |
               (~trig_q & (req_q | edge_set) & ~ack_hot);
    isr_d    = isr_q;
    rot_d    = rot_q;
    if (cmd.en) begin
      if (!auto_eoi) isr_d = isr_q | ack_hot;
      else if (rot_aeoi) rot_d = cmd.line + 1'b1;
    end
    trig_d = trig_we ? (trig_wdata & TRIG_MASK) : trig_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      req_q  <= '0;
      isr_q  <= '0;
      rot_q  <= '0;
      trig_q <= '0;
    end else begin
      last_q <= lines_in;
      req_q  <= req_d;
      isr_q  <= isr_d;
      rot_q  <= rot_d;
      trig_q <= trig_d;
    end
  end

  assert_level_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_q & $past(trig_q)) == ($past(lines_in) & $past(trig_q))));

  assert_isr_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.en && !auto_eoi) |=> isr_q[$past(cmd.line)]);

  assert_aeoi_isr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.en && auto_eoi) |=> (isr_q == $past(isr_q)));

  assert_edge_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.en && !trig_q[cmd.line]) |=> !req_q[$past(cmd.line)]);
endmodule

// File: rtl/casc_ack_decode.sv
module casc_ack_decode
  import casc_ack_pkg::*;
(
  input  logic             ack,
  input  logic             m_valid,
  input  logic [IDX_W-1:0] m_line,
  input  logic             s_valid,
  input  logic [IDX_W-1:0] s_line,
  input  logic [VEC_W-1:0] m_base,
  input  logic [VEC_W-1:0] s_base,
  output ack_cmd_t         m_cmd,
  output ack_cmd_t         s_cmd,
  output logic [VEC_W-1:0] vector
);
  localparam logic [VEC_W-1:0] LOW_MASK  = VEC_W'((1 << IDX_W) - 1);
  localparam logic [IDX_W-1:0] SPUR_LINE = IDX_W'(LINES - 1);

  logic             casc_hit;
  logic [VEC_W-1:0] m_hi, s_hi;

  always_comb begin
    m_hi       = m_base & ~LOW_MASK;
    s_hi       = s_base & ~LOW_MASK;
    casc_hit   = m_valid && (m_line == IDX_W'(CASC_LINE));
    m_cmd.en   = ack && m_valid;
    m_cmd.line = m_line;
    s_cmd.en   = ack && casc_hit && s_valid;
    s_cmd.line = s_line;
    if (!m_valid)      vector = m_hi | VEC_W'(SPUR_LINE);
    else if (casc_hit) vector = s_hi | VEC_W'(s_valid ? s_line : SPUR_LINE);
    else               vector = m_hi | VEC_W'(m_line);
  end

  always_comb begin
    if (s_cmd.en) assert_sec_only_via_casc_R8: assert (m_cmd.en && m_cmd.line == IDX_W'(CASC_LINE));
  end
endmodule

// File: rtl/casc_ack_unit.sv
module casc_ack_unit
  import casc_ack_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*LINES-1:0]   irq_in,
  input  logic                 trig_we,
  input  logic                 trig_sec,
  input  logic [LINES-1:0]     trig_wdata,
  input  logic                 pri_aeoi,
  input  logic                 pri_rot,
  input  logic                 sec_aeoi,
  input  logic                 sec_rot,
  input  logic [VEC_W-1:0]     pri_base,
  input  logic [VEC_W-1:0]     sec_base,
  input  logic                 pri_win_valid,
  input  logic [IDX_W-1:0]     pri_win_line,
  input  logic                 sec_win_valid,
  input  logic [IDX_W-1:0]     sec_win_line,
  input  logic                 ack,
  output logic [VEC_W-1:0]     vector,
  output logic [LINES-1:0]     pri_req,
  output logic [LINES-1:0]     sec_req,
  output logic [LINES-1:0]     pri_isr,
  output logic [LINES-1:0]     sec_isr,
  output logic [IDX_W-1:0]     pri_rot_base,
  output logic [IDX_W-1:0]     sec_rot_base,
  output logic [LINES-1:0]     pri_trig,
  output logic [LINES-1:0]     sec_trig
);
  localparam logic [LINES-1:0] CASC_BIT = LINES'(1) << CASC_LINE;

  logic     rst_s1, rst_i;
  ack_cmd_t m_cmd, s_cmd;
  logic [LINES-1:0] pri_lines, pri_force;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_i  <= rst_s1;
    end
  end

  always_comb begin
    pri_lines = irq_in[LINES-1:0] & ~CASC_BIT;
    pri_force = sec_win_valid ? CASC_BIT : '0;
  end

  casc_ack_decode u_dec (
    .ack(ack), .m_valid(pri_win_valid), .m_line(pri_win_line),
    .s_valid(sec_win_valid), .s_line(sec_win_line),
    .m_base(pri_base), .s_base(sec_base),
    .m_cmd(m_cmd), .s_cmd(s_cmd), .vector(vector)
  );

  casc_ack_lane #(.TRIG_MASK(PRI_TRIG_MASK)) u_pri (
    .clk(clk), .rst_n(rst_i), .lines_in(pri_lines), .force_set(pri_force),
    .trig_we(trig_we && !trig_sec), .trig_wdata(trig_wdata), .cmd(m_cmd),
    .auto_eoi(pri_aeoi), .rot_aeoi(pri_rot),
    .req_q(pri_req), .isr_q(pri_isr), .rot_q(pri_rot_base), .trig_q(pri_trig)
  );

  casc_ack_lane #(.TRIG_MASK(SEC_TRIG_MASK)) u_sec (
    .clk(clk), .rst_n(rst_i), .lines_in(irq_in[2*LINES-1:LINES]), .force_set('0),
    .trig_we(trig_we && trig_sec), .trig_wdata(trig_wdata), .cmd(s_cmd),
    .auto_eoi(sec_aeoi), .rot_aeoi(sec_rot),
    .req_q(sec_req), .isr_q(sec_isr), .rot_q(sec_rot_base), .trig_q(sec_trig)
  );

  assert_casc_forward_R4: assert property (@(posedge clk) disable iff (!rst_i)
    (sec_win_valid && !(m_cmd.en && m_cmd.line == IDX_W'(CASC_LINE))) |=> pri_req[CASC_LINE]);

  assert_trig_mask_R3: assert property (@(posedge clk) disable iff (!rst_i)
    1'b1 |=> (((pri_trig & ~PRI_TRIG_MASK) == '0) && ((sec_trig & ~SEC_TRIG_MASK) == '0)));
endmodule

// File: tb/casc_ack_unit_test.sv
module casc_ack_unit_test;
  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] irq_in;
  logic trig_we, trig_sec;
  logic [7:0] trig_wdata;
  logic pri_aeoi, pri_rot, sec_aeoi, sec_rot;
  logic [7:0] pri_base, sec_base;
  logic pri_win_valid, sec_win_valid;
  logic [2:0] pri_win_line, sec_win_line;
  logic ack;
  logic [7:0] vector, pri_req, sec_req, pri_isr, sec_isr, pri_trig, sec_trig;
  logic [2:0] pri_rot_base, sec_rot_base;

  int total = 0;
  int bad = 0;

  logic [7:0] e_req [2];
  logic [7:0] e_isr [2];
  logic [7:0] e_last [2];
  logic [7:0] e_trig [2];
  logic [2:0] e_rot [2];

  always #10 clk = ~clk;

  casc_ack_unit uut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_vec();
    if (!pri_win_valid) return {pri_base[7:3], 3'd7};
    if (pri_win_line == 3'd2) return {sec_base[7:3], sec_win_valid ? sec_win_line : 3'd7};
    return {pri_base[7:3], pri_win_line};
  endfunction

  task automatic model_step();
    logic [7:0] inp [2];
    logic [7:0] frc [2];
    logic       aen [2];
    logic [2:0] aln [2];
    logic       aeo [2];
    logic       rot [2];
    inp[0] = irq_in[7:0] & 8'hFB;  inp[1] = irq_in[15:8];
    frc[0] = sec_win_valid ? 8'h04 : 8'h00; frc[1] = 8'h00;
    aen[0] = ack && pri_win_valid;
    aen[1] = ack && pri_win_valid && pri_win_line == 3'd2 && sec_win_valid;
    aln[0] = pri_win_line; aln[1] = sec_win_line;
    aeo[0] = pri_aeoi; aeo[1] = sec_aeoi;
    rot[0] = pri_rot;  rot[1] = sec_rot;
    for (int c = 0; c < 2; c++) begin
      for (int b = 0; b < 8; b++) begin
        if (e_trig[c][b]) e_req[c][b] = inp[c][b];
        else if (aen[c] && aln[c] == 3'(b)) e_req[c][b] = 1'b0;
        else if ((inp[c][b] && !e_last[c][b]) || frc[c][b]) e_req[c][b] = 1'b1;
      end
      e_last[c] = inp[c];
      if (aen[c]) begin
        if (!aeo[c]) e_isr[c][aln[c]] = 1'b1;
        else if (rot[c]) e_rot[c] = aln[c] + 3'd1;
      end
    end
    if (trig_we) begin
      if (trig_sec) e_trig[1] = trig_wdata & 8'hDE;
      else          e_trig[0] = trig_wdata & 8'hF8;
    end
  endtask

  task automatic compare_state();
    chk("R1 R2 R4 R7 R12 pri_req", pri_req, e_req[0]);
    chk("R1 R2 R7 R8 R12 sec_req", sec_req, e_req[1]);
    chk("R5 R6 R10 pri_isr", pri_isr, e_isr[0]);
    chk("R5 R6 R8 R9 sec_isr", sec_isr, e_isr[1]);
    chk("R6 pri_rot", {5'd0, pri_rot_base}, {5'd0, e_rot[0]});
    chk("R6 sec_rot", {5'd0, sec_rot_base}, {5'd0, e_rot[1]});
    chk("R3 pri_trig", pri_trig, e_trig[0]);
    chk("R3 sec_trig", sec_trig, e_trig[1]);
  endtask

  // called just after a negedge with inputs already set
  task automatic tick();
    #1;
    if (ack) chk("R8 R9 R10 R11 vector", vector, exp_vec());
    model_step();
    @(negedge clk);
    compare_state();
  endtask

  task automatic idle_inputs();
    trig_we = 0; trig_sec = 0; trig_wdata = 0;
    ack = 0; pri_win_valid = 0; sec_win_valid = 0;
    pri_win_line = 0; sec_win_line = 0;
  endtask

  initial begin
    #4_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; irq_in = 0; idle_inputs();
    pri_aeoi = 0; pri_rot = 0; sec_aeoi = 0; sec_rot = 0;
    pri_base = 8'h20; sec_base = 8'h70;
    for (int c = 0; c < 2; c++) begin
      e_req[c] = 0; e_isr[c] = 0; e_last[c] = 0; e_trig[c] = 0; e_rot[c] = 0;
    end
    repeat (3) @(negedge clk);
    compare_state();                                 // reset state
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R3 masking
    trig_we = 1; trig_sec = 0; trig_wdata = 8'hFF; tick();
    chk("R3 pri mask direct", pri_trig, 8'hF8);
    trig_sec = 1; tick();
    chk("R3 sec mask direct", sec_trig, 8'hDE);
    trig_sec = 0; trig_wdata = 8'h08; tick();        // primary line 3 level
    trig_sec = 1; trig_wdata = 8'h00; tick();
    idle_inputs();

    // R1 edge line 0
    irq_in[0] = 1; tick();
    chk("R1 edge set", pri_req & 8'h01, 8'h01);
    tick();
    ack = 1; pri_win_valid = 1; pri_win_line = 0; tick();
    idle_inputs();
    chk("R7 edge cleared", pri_req & 8'h01, 8'h00);
    chk("R5 isr set", pri_isr & 8'h01, 8'h01);
    tick();
    chk("R1 no re-set while high", pri_req & 8'h01, 8'h00);

    // R2 level line 3, R7 level kept
    irq_in[3] = 1; tick();
    ack = 1; pri_win_valid = 1; pri_win_line = 3; tick();
    idle_inputs();
    chk("R7 level kept", pri_req & 8'h08, 8'h08);
    irq_in[3] = 0; tick();
    chk("R2 level drop", pri_req & 8'h08, 8'h00);

    // R4 cascade: input bit 2 ignored, secondary winner forwards
    irq_in[2] = 1; tick(); tick();
    chk("R4 input 2 ignored", pri_req & 8'h04, 8'h00);
    irq_in[13] = 1; tick();
    sec_win_valid = 1; sec_win_line = 5; tick();
    chk("R4 casc set", pri_req & 8'h04, 8'h04);

    // R8 chained acknowledge
    ack = 1; pri_win_valid = 1; pri_win_line = 2; tick();
    idle_inputs();
    chk("R8 sec isr", sec_isr & 8'h20, 8'h20);
    chk("R8 sec req cleared", sec_req & 8'h20, 8'h00);

    // R9 spurious on secondary
    ack = 1; pri_win_valid = 1; pri_win_line = 2; sec_win_valid = 0;
    #1; chk("R9 spurious sec vector", vector, 8'h77);
    tick(); idle_inputs();

    // R10 spurious on primary
    ack = 1; pri_win_valid = 0;
    #1; chk("R10 spurious pri vector", vector, 8'h27);
    tick(); idle_inputs();

    // R11 plain primary vector
    irq_in[5] = 1; tick();
    ack = 1; pri_win_valid = 1; pri_win_line = 5;
    #1; chk("R11 pri vector", vector, 8'h25);
    tick(); idle_inputs();

    // R6 auto-EOI with rotation
    pri_aeoi = 1; pri_rot = 1; irq_in[4] = 1; tick();
    ack = 1; pri_win_valid = 1; pri_win_line = 4; tick();
    idle_inputs();
    chk("R6 rot base", {5'd0, pri_rot_base}, 8'd5);
    chk("R6 isr unchanged", pri_isr & 8'h10, 8'h00);
    pri_aeoi = 0; pri_rot = 0;

    // R12 edge and ack together on line 1
    irq_in[1] = 1; ack = 1; pri_win_valid = 1; pri_win_line = 1; tick();
    idle_inputs();
    chk("R12 ack beats edge", pri_req & 8'h02, 8'h00);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      irq_in        = 16'($urandom) & 16'($urandom);
      trig_we       = ($urandom % 16) == 0;
      trig_sec      = 1'($urandom);
      trig_wdata    = 8'($urandom);
      pri_aeoi      = 1'($urandom); pri_rot = 1'($urandom);
      sec_aeoi      = 1'($urandom); sec_rot = 1'($urandom);
      pri_base      = 8'($urandom); sec_base = 8'($urandom);
      pri_win_valid = ($urandom % 4) != 0;
      pri_win_line  = ($urandom % 3 == 0) ? 3'd2 : 3'($urandom);
      sec_win_valid = 1'($urandom);
      sec_win_line  = 3'($urandom);
      ack           = ($urandom % 3) == 0;
      tick();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule